// File: doc/BRIEF.md
# Completion Reorder Buffer

This block restores issue order to work that finishes out of order. A requester first reserves an entry and gets back a token that names a slot. Whoever later finishes the job presents that token with the result, and the result is written into the named slot. The drain side hands results out strictly in the order the tokens were issued. A result that finishes early is held until every result reserved before it has arrived.

The slot count `SLOTS` must be a power of two, at least 2. The element width is `DATA_W`. Tokens are slot indices handed out by a reserve pointer that counts upward and wraps. A drain pointer follows the same sequence. Each slot holds a two-bit state (free, waiting, done) and one data word. Reserve, complete and drain each have their own valid/ready pair, and all three may fire in the same cycle.

Top module: `cmpl_rob`

## Requirements
- R1: After reset, `rsv_ready_o` is 1, `drn_valid_o` is 0 and `rsv_tok_o` is 0.
- R2: Every accepted reserve returns the token after the previous one, modulo `SLOTS`, starting from 0. The offered token does not change while no reserve is accepted.
- R3: `rsv_ready_o` is 0 exactly when all `SLOTS` entries are reserved and not yet drained. A reserve is never accepted into an occupied slot.
- R4: A complete (`cpl_valid_i` high) stores `cpl_data_i` in the slot named by `cpl_tok_i`, and that value is the one later drained for the token.
- R5: Drained results come out in token issue order, oldest first, and each accepted drain moves on to the next token.
- R6: `drn_valid_o` is 1 only when the oldest outstanding entry has completed. Later entries that complete early do not make it valid.
- R7: An accepted drain frees its slot, so a reserve in the following cycle can be accepted with that slot's token.
- R8: A reserve, a complete and a drain presented in the same cycle all take effect in that cycle.
- R9: `cpl_ready_o` is always 1. A complete must name a slot that is reserved and not yet completed, and any other complete is flagged as a protocol error.
- R10: While `drn_valid_o` is 1 and `drn_ready_i` is 0, `drn_valid_o` stays 1 and `drn_data_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reserve request |
| rsv_ready_o | output | 1 | A free slot is available |
| rsv_tok_o | output | $clog2(SLOTS) | Token handed out when a reserve is accepted |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_ready_o | output | 1 | Completion accepted (always 1) |
| cpl_tok_i | input | $clog2(SLOTS) | Token of the finishing entry |
| cpl_data_i | input | DATA_W | Result value |
| drn_valid_o | output | 1 | Oldest entry has completed |
| drn_ready_i | input | 1 | Consumer takes the oldest result |
| drn_data_o | output | DATA_W | Oldest result |

## Verification
The case that matters most is a full buffer where the oldest slot is drained in the same cycle that a reserve is waiting. The reserve must stay refused in that cycle and must be accepted in the next cycle with the token that was just freed. In that next cycle a completion and a further drain are also applied. The bench builds this case on purpose. It then checks the reused token, both drained values and the later drain order against values it works out itself. A sweep over every completion order of a four-slot buffer checks, after each completion, whether the drain side becomes valid.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_DONE = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= ptr_o + 1'b1;
  end

  // R2 R5
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == W'($past(ptr_o) + 1'b1));
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsv_i,
  input  logic              cpl_i,
  input  logic              drn_i,
  input  logic [DATA_W-1:0] data_i,
  output slot_st_e          state_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= SLOT_FREE;
      data_o  <= '0;
    end else begin
      if (drn_i) state_o <= SLOT_FREE;
      if (rsv_i) state_o <= SLOT_WAIT;
      if (cpl_i) begin
        state_o <= SLOT_DONE;
        data_o  <= data_i;
      end
    end
  end

  // R9
  cpl_on_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i |-> state_o == SLOT_WAIT);
  // R3
  rsv_on_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_i |-> state_o == SLOT_FREE);
  // R7
  drn_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_i |=> state_o == SLOT_FREE);
  // R6
  drn_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_i |-> state_o == SLOT_DONE);
endmodule

// File: rtl/cmpl_rob.sv
module cmpl_rob
  import rob_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  localparam int TOK_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsv_valid_i,
  output logic              rsv_ready_o,
  output logic [TOK_W-1:0]  rsv_tok_o,
  input  logic              cpl_valid_i,
  output logic              cpl_ready_o,
  input  logic [TOK_W-1:0]  cpl_tok_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  output logic              drn_valid_o,
  input  logic              drn_ready_i,
  output logic [DATA_W-1:0] drn_data_o
);
  slot_st_e          st_q  [SLOTS];
  logic [DATA_W-1:0] dat_q [SLOTS];
  logic [SLOTS-1:0]  busy;
  logic [TOK_W-1:0]  drn_ptr;
  logic              rsv_fire, drn_fire;

  // round-robin order means the slot under the reserve pointer is free iff not full
  assign rsv_ready_o = (st_q[rsv_tok_o] == SLOT_FREE);
  assign drn_valid_o = (st_q[drn_ptr] == SLOT_DONE);
  assign drn_data_o  = dat_q[drn_ptr];
  assign cpl_ready_o = 1'b1;
  assign rsv_fire    = rsv_valid_i && rsv_ready_o;
  assign drn_fire    = drn_valid_o && drn_ready_i;

  rob_ptr #(.W(TOK_W)) u_rsv_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .adv_i (rsv_fire), .ptr_o (rsv_tok_o)
  );

  rob_ptr #(.W(TOK_W)) u_drn_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .adv_i (drn_fire), .ptr_o (drn_ptr)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    rob_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rsv_i   (rsv_fire && rsv_tok_o == TOK_W'(i)),
      .cpl_i   (cpl_valid_i && cpl_tok_i == TOK_W'(i)),
      .drn_i   (drn_fire && drn_ptr == TOK_W'(i)),
      .data_i  (cpl_data_i),
      .state_o (st_q[i]),
      .data_o  (dat_q[i])
    );
    assign busy[i] = (st_q[i] != SLOT_FREE);
  end

  // R3
  full_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsv_ready_o |-> &busy);
  // R6
  empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_tok_o == drn_ptr && rsv_ready_o) |-> busy == '0);
  // R10
  drn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drn_valid_o && !drn_ready_i) |=> drn_valid_o && $stable(drn_data_o));
  // R9
  cpl_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_ready_o);
endmodule

// File: tb/cmpl_rob_tb.sv
module cmpl_rob_tb;
  localparam int SLOTS = 4;
  localparam int DW    = 16;
  localparam int TW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rsv_valid = 1'b0, rsv_ready;
  logic [TW-1:0] rsv_tok;
  logic          cpl_valid = 1'b0, cpl_ready;
  logic [TW-1:0] cpl_tok = '0;
  logic [DW-1:0] cpl_data = '0;
  logic          drn_valid, drn_ready = 1'b0;
  logic [DW-1:0] drn_data;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #5 clk = ~clk;

  cmpl_rob #(.SLOTS(SLOTS), .DATA_W(DW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .rsv_valid_i (rsv_valid), .rsv_ready_o (rsv_ready), .rsv_tok_o (rsv_tok),
    .cpl_valid_i (cpl_valid), .cpl_ready_o (cpl_ready),
    .cpl_tok_i (cpl_tok), .cpl_data_i (cpl_data),
    .drn_valid_o (drn_valid), .drn_ready_i (drn_ready), .drn_data_o (drn_data)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    rsv_valid = 1'b0; cpl_valid = 1'b0; drn_ready = 1'b0;
  endtask

  task automatic reserve(string req, int exp_tok);
    @(negedge clk); clr(); rsv_valid = 1'b1;
    #1;
    chk(req, "rsv_ready", int'(rsv_ready), 1);
    chk(req, "token", int'(rsv_tok), exp_tok);
    @(posedge clk); #1 clr();
  endtask

  task automatic complete(int tok, int data);
    @(negedge clk); clr();
    cpl_valid = 1'b1; cpl_tok = TW'(tok); cpl_data = DW'(data);
    #1 chk("R9", "cpl_ready", int'(cpl_ready), 1);
    @(posedge clk); #1 clr();
  endtask

  task automatic drain(string req, int exp_data);
    @(negedge clk); clr(); drn_ready = 1'b1;
    #1;
    chk(req, "drn_valid", int'(drn_valid), 1);
    chk("R4", "drn_data", int'(drn_data), exp_data);
    @(posedge clk); #1 clr();
  endtask

  function automatic int val(int p, int t);
    return p * 37 + t * 5 + 100;
  endfunction

  int head = 0;
  int nxt  = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk("R1", "rsv_ready", int'(rsv_ready), 1);
    chk("R1", "drn_valid", int'(drn_valid), 0);
    chk("R1", "rsv_tok", int'(rsv_tok), 0);

    // exhaustive sweep over all completion orders of a full buffer
    for (int p = 0; p < 24; p++) begin
      int avail[4];
      int order[4];
      int tokens[4];
      int rad[4];
      bit dn[4];
      int outst;
      rad[0] = p / 6; rad[1] = (p / 2) % 3; rad[2] = p % 2; rad[3] = 0;
      for (int i = 0; i < 4; i++) avail[i] = i;
      for (int k = 0; k < 4; k++) begin
        order[k] = avail[rad[k]];
        for (int j = rad[k]; j < 3 - k; j++) avail[j] = avail[j+1];
      end
      for (int k = 0; k < 4; k++) begin
        reserve("R2", nxt);
        tokens[k] = nxt;
        nxt = (nxt + 1) % SLOTS;
        dn[k] = 1'b0;
      end
      outst = 4;
      @(negedge clk); #1;
      chk("R3", "rsv_ready full", int'(rsv_ready), 0);
      chk("R6", "drn_valid none done", int'(drn_valid), 0);
      for (int k = 0; k < 4; k++) begin
        int t;
        t = tokens[order[k]];
        complete(t, val(p, t));
        dn[t] = 1'b1;
        while (dn[head]) begin
          drain("R5", val(p, head));
          dn[head] = 1'b0;
          head = (head + 1) % SLOTS;
          outst--;
        end
        @(negedge clk); #1;
        chk("R6", "drn_valid wait", int'(drn_valid), 0);
        chk("R7", "rsv_ready after drain", int'(rsv_ready), (outst < 4) ? 1 : 0);
      end
    end

    // R10: stall holds output
    reserve("R2", nxt);
    complete(nxt, 16'hABCD);
    nxt = (nxt + 1) % SLOTS;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); clr(); #1;
      chk("R10", "stall valid", int'(drn_valid), 1);
      chk("R10", "stall data", int'(drn_data), 16'hABCD);
    end
    drain("R10", 16'hABCD);
    head = (head + 1) % SLOTS;

    // R8: concurrent reserve/complete/drain with slot reuse
    begin
      int a;
      a = head;
      for (int k = 0; k < 4; k++) begin
        reserve("R2", (a + k) % SLOTS);
      end
      complete(a, 16'h1111);
      @(negedge clk); clr();
      drn_ready = 1'b1; rsv_valid = 1'b1;
      cpl_valid = 1'b1; cpl_tok = TW'((a + 1) % SLOTS); cpl_data = 16'h2222;
      #1;
      chk("R3", "full with drain pending", int'(rsv_ready), 0);
      chk("R8", "drn_valid", int'(drn_valid), 1);
      chk("R8", "drn_data first", int'(drn_data), 16'h1111);
      @(posedge clk); #1 clr();
      @(negedge clk); clr();
      drn_ready = 1'b1; rsv_valid = 1'b1;
      cpl_valid = 1'b1; cpl_tok = TW'((a + 2) % SLOTS); cpl_data = 16'h3333;
      #1;
      chk("R7", "rsv_ready after free", int'(rsv_ready), 1);
      chk("R7", "reused token", int'(rsv_tok), a);
      chk("R8", "drn_valid second", int'(drn_valid), 1);
      chk("R8", "drn_data second", int'(drn_data), 16'h2222);
      @(posedge clk); #1 clr();
      drain("R8", 16'h3333);
      @(negedge clk); #1;
      chk("R6", "oldest pending", int'(drn_valid), 0);
      complete(a, 16'h5555);
      @(negedge clk); #1;
      chk("R6", "younger done only", int'(drn_valid), 0);
      complete((a + 3) % SLOTS, 16'h4444);
      drain("R5", 16'h4444);
      drain("R5", 16'h5555);
      @(negedge clk); #1;
      chk("R2", "next token", int'(rsv_tok), (a + 1) % SLOTS);
      chk("R3", "empty ready", int'(rsv_ready), 1);
      chk("R6", "empty not valid", int'(drn_valid), 0);
    end

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule